// File: doc/BRIEF.md
# Dual-Format Stereo Audio Serializer

This block takes one pair of 16-bit two's-complement stereo samples per sample period (rate Fs) and drives them onto a single 16-bit pin group. A select input picks the output form. In parallel form the pins carry the current channel's sample word directly, and a strobe shows which channel is present. In serial form the same pins carry two framed serial streams at the same time. One stream uses 48 bit periods per frame and sends most significant bit first. The other uses 64 bit periods per frame and sends least significant bit first. Each stream drives its own bit clock and LR clock. The 48-bit stream also has a word clock, which runs at twice Fs.

All timing comes from one master clock. Two parameters set the half bit period, counted in master clocks, for each stream. They must be chosen so that both streams have the same frame length in master clocks. With the default values the frame is 384 master clocks long. A new sample pair is captured once per frame, on the last master clock of the frame, so the words being shifted never change in the middle of a frame.

Top module: `aud_dual_ser`

## Requirements
- R1: When `par_sel_i` is high, `pins_o` shows the parallel word. When it is low, `pins_o` shows the serial mapping. A change of `par_sel_i` reaches `pins_o` with no register delay.
- R2: The 48-slot data (`pins_o[15]`) carries the 16 sample bits most significant bit first, at bit positions 0..15 of each 24-bit half-frame. The remaining 8 positions of the half-frame are 0.
- R3: The 64-slot data (`pins_o[13]`) carries the 16 sample bits least significant bit first, at bit positions 0..15 of each 32-bit half-frame. The remaining 16 positions of the half-frame are 0.
- R4: The 48-slot bit clock (`pins_o[14]`) is low for the first HALF_A master clocks of each bit period and high for the next HALF_A. It has 48 rising edges per frame. `wclk48_o` is high for the first 12 bit periods of each half-frame, so it falls twice per frame.
- R5: The 64-slot bit clock (`pins_o[12]`) is low for the first HALF_B master clocks of each bit period and high for the next HALF_B, with 64 rising edges per frame. The 64-slot LR clock is on `pins_o[11]`. Both streams start their frames on the same master clock.
- R6: Each LR clock (`lr48_o` and `pins_o[11]`) is high during the left half-frame and low during the right half-frame. It changes only in the cycle where its own bit clock falls.
- R7: The input pair is captured only on the last master clock of a frame. Input changes at any other time have no effect on the outputs during the current frame.
- R8: In parallel mode, `pins_o` holds the left word while `lr48_o` is high and the right word while `lr48_o` is low. The word's MSB is on `pins_o[15]`.
- R9: While `rst` is high, the held pair is zero and both streams sit at frame start. In serial mode this gives `pins_o` = 16'h0800, `wclk48_o` = 1 and `lr48_o` = 1. In parallel mode it gives `pins_o` = 0.
- R10: In serial mode, `pins_o[10:0]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| par_sel_i | input | 1 | Output form select: 1 = parallel, 0 = serial |
| left_i | input | 16 | Left-channel sample, two's complement |
| right_i | input | 16 | Right-channel sample, two's complement |
| pins_o | output | 16 | Shared pins: parallel word, or the serial streams and their clocks |
| wclk48_o | output | 1 | Word clock of the 48-slot stream, at 2·Fs |
| lr48_o | output | 1 | LR clock of the 48-slot stream; in parallel mode, the channel strobe |

## Verification
Two events can fall on the same cycle at a frame boundary. The held sample pair is reloaded, and both streams' LR clocks and bit clocks wrap. The bench adds a third event on that same edge: it changes the mode select together with new input data in the last cycle of a frame. It then expects the first cycle of the next frame to show the newly captured left word in parallel form, with the channel strobe high. In a second test the inputs change in the middle of a frame. The bench judges the whole remaining frame, cycle by cycle, against a model that keeps the old pair.

// File: rtl/aud_ser_pkg.sv
`timescale 1ns/1ps
package aud_ser_pkg;

    localparam int SAMPLE_W = 16;
    localparam int SEL_W    = $clog2(SAMPLE_W);

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } stereo_t;

    typedef enum logic {
        MODE_SERIAL   = 1'b0,
        MODE_PARALLEL = 1'b1
    } out_mode_e;

    typedef struct packed {
        logic sdata;
        logic bclk;
        logic lrclk;
        logic wclk;
        logic frame_end;
    } lane_t;

    // Bit of a sample word at slot position idx; positions past the word are zero.
    function automatic logic pick_bit(sample_t w, logic [31:0] idx, logic msb_first);
        logic [SEL_W-1:0] sel;
        if (idx >= 32'(SAMPLE_W)) return 1'b0;
        sel = SEL_W'(idx);
        return msb_first ? w[SEL_W'(SAMPLE_W-1) - sel] : w[sel];
    endfunction

endpackage

// File: rtl/aud_ser_lane.sv
`timescale 1ns/1ps
module aud_ser_lane
    import aud_ser_pkg::*;
#(
    parameter int SLOT      = 48,
    parameter int HALF      = 4,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  stereo_t pair_i,
    output lane_t   lane_o
);
    localparam int PER       = 2 * HALF;
    localparam int PH_W      = $clog2(PER);
    localparam int POS_W     = $clog2(SLOT);
    localparam int HALF_SLOT = SLOT / 2;
    localparam int QTR_SLOT  = SLOT / 4;

    logic [PH_W-1:0]  ph_q;
    logic [POS_W-1:0] pos_q;
    logic             in_right;
    logic [POS_W-1:0] idx;
    sample_t          word;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q  <= '0;
            pos_q <= '0;
        end else if (ph_q == PH_W'(PER - 1)) begin
            ph_q  <= '0;
            pos_q <= (pos_q == POS_W'(SLOT - 1)) ? '0 : pos_q + 1'b1;
        end else begin
            ph_q  <= ph_q + 1'b1;
        end
    end

    always_comb begin
        in_right         = (pos_q >= POS_W'(HALF_SLOT));
        idx              = in_right ? (pos_q - POS_W'(HALF_SLOT)) : pos_q;
        word             = in_right ? pair_i.right : pair_i.left;
        lane_o.sdata     = pick_bit(word, 32'(idx), MSB_FIRST);
        lane_o.bclk      = (ph_q >= PH_W'(HALF));
        lane_o.lrclk     = ~in_right;
        lane_o.wclk      = (idx < POS_W'(QTR_SLOT));
        lane_o.frame_end = (pos_q == POS_W'(SLOT - 1)) && (ph_q == PH_W'(PER - 1));
    end

    // LR clock moves only together with a falling bit clock.
    p_lr_on_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (lane_o.lrclk != $past(lane_o.lrclk)) |-> (!lane_o.bclk && $past(lane_o.bclk)));

    // Word clock also moves only on a falling bit clock.
    p_wclk_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (lane_o.wclk != $past(lane_o.wclk)) |-> (!lane_o.bclk && $past(lane_o.bclk)));

    // After the last cycle of a frame the lane is back at left, bit clock low.
    p_frame_restart_r6: assert property (@(posedge clk) disable iff (rst)
        lane_o.frame_end |=> (lane_o.lrclk && !lane_o.bclk));

endmodule

// File: rtl/aud_pair_latch.sv
`timescale 1ns/1ps
module aud_pair_latch
    import aud_ser_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  sample_t left_i,
    input  sample_t right_i,
    output stereo_t pair_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pair_o <= '0;
        end else if (load_i) begin
            pair_o.left  <= left_i;
            pair_o.right <= right_i;
        end
    end

    // Held pair changes only after a frame-end load.
    p_hold_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
        (pair_o != $past(pair_o)) |-> $past(load_i));

endmodule

// File: rtl/aud_pin_mux.sv
`timescale 1ns/1ps
module aud_pin_mux
    import aud_ser_pkg::*;
(
    input  logic                par_sel_i,
    input  stereo_t             pair_i,
    input  logic                chan_left_i,
    input  logic                a_data_i,
    input  logic                a_bclk_i,
    input  logic                b_data_i,
    input  logic                b_bclk_i,
    input  logic                b_lr_i,
    output logic [SAMPLE_W-1:0] pins_o
);
    localparam int N_SER = 5;

    logic [N_SER-1:0]    ser_bits;
    logic [SAMPLE_W-1:0] ser_word;
    out_mode_e           mode;

    assign mode     = out_mode_e'(par_sel_i);
    assign ser_bits = {a_data_i, a_bclk_i, b_data_i, b_bclk_i, b_lr_i};

    for (genvar g = 0; g < SAMPLE_W; g++) begin : g_ser_map
        if (g >= SAMPLE_W - N_SER) begin : g_used
            assign ser_word[g] = ser_bits[g - (SAMPLE_W - N_SER)];
        end else begin : g_idle
            assign ser_word[g] = 1'b0;
        end
    end

    always_comb begin
        if (mode == MODE_PARALLEL) pins_o = chan_left_i ? pair_i.left : pair_i.right;
        else                       pins_o = ser_word;
    end

endmodule

// File: rtl/aud_dual_ser.sv
`timescale 1ns/1ps
module aud_dual_ser
    import aud_ser_pkg::*;
#(
    parameter int SLOT_A = 48,
    parameter int HALF_A = 4,
    parameter int SLOT_B = 64,
    parameter int HALF_B = 3
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        par_sel_i,
    input  logic [15:0] left_i,
    input  logic [15:0] right_i,
    output logic [15:0] pins_o,
    output logic        wclk48_o,
    output logic        lr48_o
);
    localparam int FRAME_A = SLOT_A * 2 * HALF_A;
    localparam int FRAME_B = SLOT_B * 2 * HALF_B;

    stereo_t pair;
    lane_t   lane_a;
    lane_t   lane_b;

    aud_pair_latch u_latch (
        .clk     (clk),
        .rst     (rst),
        .load_i  (lane_a.frame_end),
        .left_i  (left_i),
        .right_i (right_i),
        .pair_o  (pair)
    );

    aud_ser_lane #(.SLOT(SLOT_A), .HALF(HALF_A), .MSB_FIRST(1'b1)) u_lane_a (
        .clk    (clk),
        .rst    (rst),
        .pair_i (pair),
        .lane_o (lane_a)
    );

    aud_ser_lane #(.SLOT(SLOT_B), .HALF(HALF_B), .MSB_FIRST(1'b0)) u_lane_b (
        .clk    (clk),
        .rst    (rst),
        .pair_i (pair),
        .lane_o (lane_b)
    );

    aud_pin_mux u_mux (
        .par_sel_i   (par_sel_i),
        .pair_i      (pair),
        .chan_left_i (lane_a.lrclk),
        .a_data_i    (lane_a.sdata),
        .a_bclk_i    (lane_a.bclk),
        .b_data_i    (lane_b.sdata),
        .b_bclk_i    (lane_b.bclk),
        .b_lr_i      (lane_b.lrclk),
        .pins_o      (pins_o)
    );

    assign wclk48_o = lane_a.wclk;
    assign lr48_o   = lane_a.lrclk;

    // Both framings must share one frame length, so frame ends coincide.
    p_frames_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        (FRAME_A == FRAME_B) && (lane_a.frame_end == lane_b.frame_end));

    // Both LR clocks agree on the channel at every cycle.
    p_lr_agree_r6: assert property (@(posedge clk) disable iff (rst)
        lane_a.lrclk == lane_b.lrclk);

    // Second stream's word-rate marker also moves only on its falling bit clock.
    p_lane_b_wclk_r5: assert property (@(posedge clk) disable iff (rst)
        (lane_b.wclk != $past(lane_b.wclk)) |-> !lane_b.bclk);

endmodule

// File: tb/aud_dual_ser_tb.sv
`timescale 1ns/1ps
module aud_dual_ser_tb_top;
    localparam int SA    = 48;
    localparam int HA    = 4;
    localparam int SB    = 64;
    localparam int HB    = 3;
    localparam int FRAME = SA * 2 * HA;
    localparam int NVEC  = 6;

    // {par_sel, left, right}
    localparam logic [32:0] VEC [NVEC] = '{
        {1'b0, 16'h8001, 16'h1234},
        {1'b0, 16'hFFFF, 16'h0000},
        {1'b1, 16'hA5C3, 16'h5A3C},
        {1'b0, 16'h0F0F, 16'hF00F},
        {1'b1, 16'h7FFF, 16'h8000},
        {1'b0, 16'h0001, 16'h8000}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        par_sel;
    logic [15:0] left_s;
    logic [15:0] right_s;
    logic [15:0] pins;
    logic        wclk48;
    logic        lr48;

    int          tk;
    logic [15:0] exp_l;
    logic [15:0] exp_r;
    int          checks = 0;
    int          errors = 0;
    bit          done   = 1'b0;

    always #4 clk = ~clk;

    aud_dual_ser dut_i (
        .clk       (clk),
        .rst       (rst),
        .par_sel_i (par_sel),
        .left_i    (left_s),
        .right_i   (right_s),
        .pins_o    (pins),
        .wclk48_o  (wclk48),
        .lr48_o    (lr48)
    );

    // Bench time base and captured pair (R7: capture on last cycle of a frame).
    always @(posedge clk) begin
        if (rst) begin
            tk    <= 0;
            exp_l <= '0;
            exp_r <= '0;
        end else begin
            tk <= tk + 1;
            if ((tk % FRAME) == FRAME - 1) begin
                exp_l <= left_s;
                exp_r <= right_s;
            end
        end
    end

    // Expected {pins, wclk48, lr48} from the requirements.
    function automatic logic [17:0] model(int t, logic ps, logic [15:0] l, logic [15:0] r);
        int f, pa, ia, pb, ib;
        logic ra, rb, ba, bb, da, db, wa;
        logic [15:0] wa_w, wb_w, pv;
        f    = t % FRAME;
        pa   = f / (2 * HA);
        ba   = (f % (2 * HA)) >= HA;
        ra   = pa >= SA / 2;
        ia   = ra ? pa - SA / 2 : pa;
        wa_w = ra ? r : l;
        da   = (ia < 16) ? wa_w[15 - ia] : 1'b0;
        wa   = ia < SA / 4;
        pb   = f / (2 * HB);
        bb   = (f % (2 * HB)) >= HB;
        rb   = pb >= SB / 2;
        ib   = rb ? pb - SB / 2 : pb;
        wb_w = rb ? r : l;
        db   = (ib < 16) ? wb_w[ib] : 1'b0;
        pv   = ps ? (ra ? r : l) : {da, ba, db, bb, ~rb, 11'b0};
        return {pv, wa, ~ra};
    endfunction

    task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s t=%0d actual=%h expected=%h", req, tk, act, expv);
        end
    endtask

    task automatic check_cycle();
        logic [17:0] e;
        e = model(tk, par_sel, exp_l, exp_r);
        if (par_sel) begin
            chk(pins == e[17:2], "R8 parallel word", pins, e[17:2]);
        end else begin
            chk(pins[15] == e[17], "R2 48-slot data", 16'(pins[15]), 16'(e[17]));
            chk(pins[14] == e[16], "R4 48-slot bclk", 16'(pins[14]), 16'(e[16]));
            chk(pins[13] == e[15], "R3 64-slot data", 16'(pins[13]), 16'(e[15]));
            chk(pins[12] == e[14], "R5 64-slot bclk", 16'(pins[12]), 16'(e[14]));
            chk(pins[11] == e[13], "R6 64-slot lr", 16'(pins[11]), 16'(e[13]));
            chk(pins[10:0] == 11'd0, "R10 idle pins", 16'(pins[10:0]), 16'd0);
        end
        chk(wclk48 == e[1], "R4 word clock", 16'(wclk48), 16'(e[1]));
        chk(lr48 == e[0], "R6 48-slot lr", 16'(lr48), 16'(e[0]));
    endtask

    task automatic align(int target);
        do @(negedge clk); while ((tk % FRAME) != target);
    endtask

    initial begin
        int rises_a, rises_b, lr_hi, wfalls;
        logic pa, pb, pw;
        rst = 1'b1; par_sel = 1'b0; left_s = '0; right_s = '0;
        repeat (3) @(negedge clk);
        // R9 reset state, serial then parallel
        chk(pins == 16'h0800, "R9 reset serial pins", pins, 16'h0800);
        chk(wclk48 == 1'b1, "R9 reset wclk", 16'(wclk48), 16'd1);
        chk(lr48 == 1'b1, "R9 reset lr", 16'(lr48), 16'd1);
        par_sel = 1'b1; left_s = 16'hA5C3;
        @(negedge clk);
        chk(pins == 16'h0000, "R9 reset parallel pins", pins, 16'h0000);
        @(negedge clk);
        rst = 1'b0; par_sel = 1'b0;

        // Vector table: one full frame checked per entry
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            par_sel = VEC[i][32]; left_s = VEC[i][31:16]; right_s = VEC[i][15:0];
            align(0);
            for (int c = 0; c < FRAME; c++) begin
                check_cycle();
                if (c != FRAME - 1) @(negedge clk);
            end
        end

        // R4/R5: edge counts over one serial frame
        par_sel = 1'b0;
        align(0);
        rises_a = 0; rises_b = 0; lr_hi = 0; wfalls = 0;
        pa = pins[14]; pb = pins[12]; pw = wclk48;
        for (int c = 0; c < FRAME; c++) begin
            if (c != 0) @(negedge clk);
            if (pins[14] && !pa) rises_a++;
            if (pins[12] && !pb) rises_b++;
            if (!wclk48 && pw) wfalls++;
            if (lr48) lr_hi++;
            pa = pins[14]; pb = pins[12]; pw = wclk48;
        end
        chk(rises_a == SA, "R4 48-slot rises/frame", 16'(rises_a), 16'(SA));
        chk(rises_b == SB, "R5 64-slot rises/frame", 16'(rises_b), 16'(SB));
        chk(wfalls == 2, "R4 wclk falls/frame", 16'(wfalls), 16'd2);
        chk(lr_hi == FRAME / 2, "R6 lr high cycles", 16'(lr_hi), 16'(FRAME / 2));

        // R7: inputs changed mid-frame have no effect in this frame
        par_sel = 1'b1; left_s = 16'h1357; right_s = 16'h2468;
        align(0);
        repeat (100) begin check_cycle(); @(negedge clk); end
        left_s = 16'hDEAD; right_s = 16'hBEEF;
        chk(pins == 16'h1357, "R7 held left after input change", pins, 16'h1357);
        while ((tk % FRAME) != FRAME - 1) begin check_cycle(); @(negedge clk); end
        chk(pins == 16'h2468, "R7 held right at frame end", pins, 16'h2468);

        // R1 + R7: mode switch and new data on the boundary cycle
        par_sel = 1'b0;
        align(FRAME - 1);
        par_sel = 1'b1; left_s = 16'h7E01; right_s = 16'h0F0F;
        @(negedge clk);
        chk(pins == 16'h7E01, "R1 parallel at frame start", pins, 16'h7E01);
        chk(lr48 == 1'b1, "R8 strobe left", 16'(lr48), 16'd1);
        align(FRAME / 2);
        chk(pins == 16'h0F0F, "R8 right half word", pins, 16'h0F0F);
        chk(lr48 == 1'b0, "R8 strobe right", 16'(lr48), 16'd0);
        par_sel = 1'b0;
        #1;
        chk(pins == model(tk, 1'b0, exp_l, exp_r) >> 2, "R1 immediate serial", pins,
            16'(model(tk, 1'b0, exp_l, exp_r) >> 2));
        @(negedge clk);
        check_cycle();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog t=%0d actual=hung expected=done", tk);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule